// File: doc/BRIEF.md
# OSD character raster generator

This block draws a text overlay for a video monitor. The host fills a character store of 10 rows by 24 columns, one byte per cell. The block tracks the scan position from two active-low flyback inputs. Each frame starts at the falling edge of the vertical input, and each scan line starts at the falling edge of the horizontal input. When the scan position falls inside the programmed frame, the block looks up each cell's code, takes one 12-dot line of its glyph from a computed 128-code character table, and shifts that line out one dot per clock.

Software sets where the frame starts on the screen: a dot offset from the horizontal edge and a line offset from the vertical edge. It also sets how many scan lines each glyph line takes. Each character row can be drawn wide, tall, both or normal, chosen by two bits per row. The colour stage receives the lit-dot output, a frame-active flag, and the row and column of the cell being drawn.

Top module: `osd_raster_gen`

## Requirements
- R1: After reset, `dot_on` and `in_frame` stay 0, and nothing is drawn until the first falling edge of `vflb_n` has been seen.
- R2: A write with `wr_en` high stores `wr_data` in cell `wr_addr` = row*24 + column. Bit 7 of a stored code is ignored. A code whose low 7 bits are 0 draws an empty cell.
- R3: For a non-zero 7-bit code c and glyph line g, the 12-dot pattern is {c[3:0], g[3:0], c[6:4], 1}. Bit 11 is drawn first. Columns 0 to 23 follow each other with no gap.
- R4: Call E0 the clock edge that first samples `hflb_n` low after it was high. On a drawn line, the first dot of column 0 appears just after edge E0 + `h_start` + 1. In a normal-width row, each dot lasts one clock.
- R5: The line that holds a `vflb_n` falling edge is line 0. Each later `hflb_n` falling edge moves to the next line. Glyph line 0 of row 0 is on line `v_start`.
- R6: Each glyph line is repeated on `line_rep`+1 consecutive scan lines, so a normal row spans 16*(`line_rep`+1) lines.
- R7: When bit 2r+1 of `row_size` is set, row r is tall: each glyph line takes twice as many scan lines.
- R8: When bit 2r of `row_size` is set, row r is wide: each dot is held for two clocks, so one character spans 24 clocks.
- R9: Nothing is drawn after column 23 of a line or after glyph line 15 of row 9.
- R10: `in_frame` is 1 exactly while a cell dot is being shown. During that time, `char_row` and `char_col` give that cell's row and column, and `dot_on` can be 1 only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hflb_n | input | 1 | Horizontal flyback, line starts on its falling edge |
| vflb_n | input | 1 | Vertical flyback, frame starts on its falling edge |
| wr_en | input | 1 | Character store write strobe |
| wr_addr | input | 9 | Cell index, row*24 + column |
| wr_data | input | 8 | Character code |
| h_start | input | 8 | Dot offset of column 0 from the line edge |
| v_start | input | 8 | Line offset of row 0 from the frame edge |
| line_rep | input | 2 | Extra scan lines per glyph line |
| row_size | input | 20 | Per-row size bits: bit 2r wide, bit 2r+1 tall |
| dot_on | output | 1 | Current dot is lit |
| in_frame | output | 1 | A cell dot is being shown |
| char_row | output | 4 | Row of the cell being drawn |
| char_col | output | 5 | Column of the cell being drawn |

## Verification
The assertions assume that each flyback pulse stays low for more than one clock. They also assume that `h_start`, `v_start`, `line_rep` and `row_size` change only between lines and take effect on a fresh frame, so that a row's size does not change while it is being drawn. The bench sets all settings and then starts a new frame. It spaces horizontal pulses further apart than the longest drawn line (h_start + 2 + 576 clocks for a wide row), so no line is cut short by the next edge. Writes to the character store happen only while no frame is being checked.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int ROWS       = 10;
  localparam int COLS       = 24;
  localparam int CELL_W     = 12;
  localparam int CELL_H     = 16;
  localparam int CODE_W     = 8;
  localparam int GLYPH_BITS = 7;
  localparam int ADDR_W     = 9;
  localparam int CELLS      = ROWS * COLS;
  localparam int ROW_W      = $clog2(ROWS + 1);
  localparam int COL_W      = $clog2(COLS + 1);
  localparam int LINE_W     = $clog2(CELL_H);
  localparam int DOT_W      = $clog2(CELL_W);
  localparam int REP_W      = 4;
  localparam int SIZE_W     = 2 * ROWS;
  localparam int POS_W      = 8;
  localparam int CNT_W      = 10;

  typedef struct packed {
    logic tall;
    logic wide;
  } row_size_t;

  // Character table, computed: code 0 is blank, else a pattern built from code and line.
  function automatic logic [CELL_W-1:0] glyph_row(input logic [CODE_W-1:0] code,
                                                  input logic [LINE_W-1:0] gl);
    logic [GLYPH_BITS-1:0] c;
    c = code[GLYPH_BITS-1:0];
    if (c == '0) return '0;
    return {c[3:0], gl, c[6:4], 1'b1};
  endfunction

  function automatic logic [ADDR_W-1:0] cell_addr(input logic [ROW_W-1:0] r,
                                                  input logic [COL_W-1:0] c);
    return ADDR_W'(r) * ADDR_W'(COLS) + ADDR_W'(c);
  endfunction

  function automatic logic [REP_W-1:0] line_reps(input logic [1:0] rep, input logic tall);
    logic [REP_W-1:0] base;
    base = REP_W'(rep) + REP_W'(1);
    return tall ? (base << 1) : base;
  endfunction

  function automatic row_size_t size_of(input logic [SIZE_W-1:0] v, input logic [ROW_W-1:0] r);
    if (32'(r) >= ROWS) return '0;
    return row_size_t'(v[2*32'(r) +: 2]);
  endfunction
endpackage

// File: rtl/osd_fall_det.sv
module osd_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_n,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level_n;
  end

  assign fall = prev_q & ~level_n;

  // R4: an edge is reported for one clock only
  assert_fall_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/osd_code_ram.sv
module osd_code_ram
  import osd_pkg::*;
#(
  parameter int DEPTH = CELLS,
  parameter int AW    = ADDR_W,
  parameter int DW    = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic          wr_ok;

  assign wr_ok = wr_en && (wr_addr < AW'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr[IW-1:0]] <= wr_data;
  end

  assign rd_data = (rd_addr < AW'(DEPTH)) ? mem[rd_addr[IW-1:0]] : '0;

  assert_ram_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (mem[$past(wr_addr[IW-1:0])] == $past(wr_data)));
endmodule

// File: rtl/osd_vtrack.sv
module osd_vtrack
  import osd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hfall,
  input  logic              vfall,
  input  logic [POS_W-1:0]  v_start,
  input  logic [1:0]        line_rep,
  input  logic [SIZE_W-1:0] row_size,
  output logic [ROW_W-1:0]  vrow,
  output logic [LINE_W-1:0] gline,
  output logic              vact
);
  logic [CNT_W-1:0] line_cnt;
  logic [REP_W-1:0] rep;
  logic [REP_W-1:0] reps;
  row_size_t        cur;

  assign cur  = size_of(row_size, vrow);
  assign reps = line_reps(line_rep, cur.tall);
  assign vact = (line_cnt >= CNT_W'(v_start)) && (vrow < ROW_W'(ROWS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt <= '0;
      vrow     <= ROW_W'(ROWS);
      gline    <= '0;
      rep      <= '0;
    end else if (vfall) begin
      line_cnt <= '0;
      vrow     <= '0;
      gline    <= '0;
      rep      <= '0;
    end else if (hfall) begin
      if (line_cnt != '1) line_cnt <= line_cnt + CNT_W'(1);
      if (vact) begin
        if (rep + REP_W'(1) < reps) begin
          rep <= rep + REP_W'(1);
        end else begin
          rep <= '0;
          if (gline == LINE_W'(CELL_H - 1)) begin
            gline <= '0;
            vrow  <= vrow + ROW_W'(1);
          end else begin
            gline <= gline + LINE_W'(1);
          end
        end
      end
    end
  end

  assert_vsync_home_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vfall |=> (vrow == '0 && gline == '0));

  assert_line_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hfall && !vfall) |=> ($stable(vrow) && $stable(gline)));
endmodule

// File: rtl/osd_dot_shifter.sv
module osd_dot_shifter
  import osd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hfall,
  input  logic              vact,
  input  logic [ROW_W-1:0]  vrow,
  input  logic [LINE_W-1:0] gline,
  input  logic [SIZE_W-1:0] row_size,
  input  logic [POS_W-1:0]  h_start,
  input  logic [CODE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              dot_on,
  output logic              hact,
  output logic [COL_W-1:0]  hcol
);
  logic [CNT_W-1:0]  dot_cnt;
  logic [DOT_W-1:0]  hdot;
  logic              hsub;
  logic [CELL_W-1:0] shreg;
  logic              wide, start, last_dot, last_col;
  logic [COL_W-1:0]  fetch_col;
  row_size_t         cur;

  assign cur       = size_of(row_size, vrow);
  assign wide      = cur.wide;
  assign start     = !hact && vact && (dot_cnt == CNT_W'(h_start));
  assign last_dot  = (hdot == DOT_W'(CELL_W - 1));
  assign last_col  = (hcol == COL_W'(COLS - 1));
  assign fetch_col = hact ? hcol + COL_W'(1) : '0;
  assign rd_addr   = cell_addr(vrow, fetch_col);
  assign dot_on    = hact & shreg[CELL_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_cnt <= '0;
      hact    <= 1'b0;
      hcol    <= '0;
      hdot    <= '0;
      hsub    <= 1'b0;
      shreg   <= '0;
    end else if (hfall) begin
      dot_cnt <= '0;
      hact    <= 1'b0;
      hsub    <= 1'b0;
    end else begin
      if (dot_cnt != '1) dot_cnt <= dot_cnt + CNT_W'(1);
      if (start) begin
        hact  <= 1'b1;
        hcol  <= '0;
        hdot  <= '0;
        hsub  <= 1'b0;
        shreg <= glyph_row(rd_data, gline);
      end else if (hact) begin
        if (wide && !hsub) begin
          hsub <= 1'b1;
        end else begin
          hsub <= 1'b0;
          if (!last_dot) begin
            hdot  <= hdot + DOT_W'(1);
            shreg <= shreg << 1;
          end else if (!last_col) begin
            hdot  <= '0;
            hcol  <= hcol + COL_W'(1);
            shreg <= glyph_row(rd_data, gline);
          end else begin
            hact <= 1'b0;
          end
        end
      end
    end
  end

  assert_hsync_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hfall |=> (!hact && !hsub));

  assert_col_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hact |-> (hcol < COL_W'(COLS)));

  assert_wide_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hact && wide && !hsub && !hfall) |=>
      (hact && hdot == $past(hdot) && hcol == $past(hcol)));
endmodule

// File: rtl/osd_raster_gen.sv
module osd_raster_gen
  import osd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hflb_n,
  input  logic              vflb_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [POS_W-1:0]  h_start,
  input  logic [POS_W-1:0]  v_start,
  input  logic [1:0]        line_rep,
  input  logic [SIZE_W-1:0] row_size,
  output logic              dot_on,
  output logic              in_frame,
  output logic [ROW_W-1:0]  char_row,
  output logic [COL_W-1:0]  char_col
);
  logic              hfall, vfall, vact, hact;
  logic [ROW_W-1:0]  vrow;
  logic [LINE_W-1:0] gline;
  logic [ADDR_W-1:0] rd_addr;
  logic [CODE_W-1:0] rd_data;
  logic [COL_W-1:0]  hcol;

  osd_fall_det u_hdet (.clk(clk), .rst_n(rst_n), .level_n(hflb_n), .fall(hfall));
  osd_fall_det u_vdet (.clk(clk), .rst_n(rst_n), .level_n(vflb_n), .fall(vfall));

  osd_vtrack u_vtrack (
    .clk(clk), .rst_n(rst_n), .hfall(hfall), .vfall(vfall),
    .v_start(v_start), .line_rep(line_rep), .row_size(row_size),
    .vrow(vrow), .gline(gline), .vact(vact)
  );

  osd_code_ram u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  osd_dot_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .hfall(hfall), .vact(vact), .vrow(vrow), .gline(gline),
    .row_size(row_size), .h_start(h_start), .rd_data(rd_data), .rd_addr(rd_addr),
    .dot_on(dot_on), .hact(hact), .hcol(hcol)
  );

  assign in_frame = hact;
  assign char_row = vrow;
  assign char_col = hcol;
endmodule

// File: tb/osd_raster_gen_test.sv
module osd_raster_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXLEN     = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hflb_n = 1'b1, vflb_n = 1'b1;
  logic wr_en = 1'b0;
  logic [8:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] h_start = '0, v_start = '0;
  logic [1:0] line_rep = '0;
  logic [19:0] row_size = '0;
  logic dot_on, in_frame;
  logic [3:0] char_row;
  logic [4:0] char_col;

  int checks = 0, errors = 0;
  int hs = 0, vs = 0, lh = 0;
  logic [19:0] rs = '0;
  bit framed = 0;
  logic [7:0] mirror [0:239];
  logic       cap_dot [0:MAXLEN-1];
  logic       cap_in  [0:MAXLEN-1];
  logic [3:0] cap_row [0:MAXLEN-1];
  logic [4:0] cap_col [0:MAXLEN-1];

  osd_raster_gen uut (
    .clk(clk), .rst_n(rst_n), .hflb_n(hflb_n), .vflb_n(vflb_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .h_start(h_start), .v_start(v_start), .line_rep(line_rep), .row_size(row_size),
    .dot_on(dot_on), .in_frame(in_frame), .char_row(char_row), .char_col(char_col)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual run still busy, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [11:0] exp_glyph(input int code, input int gl);
    int c;
    c = code % 128;
    if (c == 0) return 12'h000;
    return 12'((c % 16) * 256 + gl * 16 + (c / 16) * 2 + 1);
  endfunction

  // Where scan line ln falls in the frame: row r, glyph line g.
  task automatic locate(input int ln, output bit ok, output int r, output int g);
    int rel, per;
    ok = 0; r = 0; g = 0;
    rel = ln - vs;
    if (rel < 0) return;
    for (int k = 0; k < 10; k++) begin
      per = (lh + 1) * (rs[2*k+1] ? 2 : 1);
      if (rel < 16 * per) begin
        ok = 1; r = k; g = rel / per;
        return;
      end
      rel -= 16 * per;
    end
  endtask

  task automatic set_mode(input int h, input int v, input int l, input logic [19:0] s);
    @(negedge clk);
    hs = h; vs = v; lh = l; rs = s;
    h_start = 8'(h); v_start = 8'(v); line_rep = 2'(l); row_size = s;
  endtask

  task automatic write_cell(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 9'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mirror[a] = d;
  endtask

  task automatic run_line(input int len, input bit vsync);
    @(negedge clk);
    hflb_n = 1'b0;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      if (i == 4) hflb_n = 1'b1;
      if (vsync && i == 8) vflb_n = 1'b0;
      if (vsync && i == 12) vflb_n = 1'b1;
      cap_dot[i] = dot_on; cap_in[i] = in_frame;
      cap_row[i] = char_row; cap_col[i] = char_col;
    end
    if (vsync) framed = 1;
  endtask

  task automatic check_line(input int ln, input int len, input string req);
    bit ok, e_in, e_dot, bad;
    int r, g, pw, rel, p, col, d, nbad;
    logic [11:0] pat;
    nbad = 0;
    locate(ln, ok, r, g);
    for (int i = 1; i < len; i++) begin
      e_in = 0; e_dot = 0; col = 0;
      if (framed && ok) begin
        pw = rs[2*r] ? 2 : 1;
        rel = i - (hs + 2);
        if (rel >= 0 && rel / pw < 288) begin
          p = rel / pw; col = p / 12; d = p % 12;
          pat = exp_glyph(int'(mirror[r*24+col]), g);
          e_in = 1; e_dot = pat[11-d];
        end
      end
      bad = (cap_dot[i] !== e_dot) || (cap_in[i] !== e_in);
      if (e_in && (int'(cap_row[i]) != r || int'(cap_col[i]) != col)) bad = 1;
      if (bad) begin
        if (nbad == 0)
          $display("FAIL %s line %0d clk %0d: dot/in/row/col actual %b/%b/%0d/%0d expected %b/%b/%0d/%0d",
                   req, ln, i, cap_dot[i], cap_in[i], cap_row[i], cap_col[i],
                   e_dot, e_in, e_in ? r : int'(cap_row[i]), e_in ? col : int'(cap_col[i]));
        nbad++;
      end
    end
    checks++;
    if (nbad != 0) errors++;
  endtask

  task automatic run_frame(input int len, input int last, input int picks[$], input string tags[$]);
    run_line(len, 1);
    for (int k = 1; k <= last; k++) begin
      run_line(len, 0);
      for (int j = 0; j < picks.size(); j++)
        if (picks[j] == k) check_line(k, len, tags[j]);
    end
  endtask

  // R1: idle outputs after reset and no drawing before a frame edge
  task automatic test_reset();
    checks++;
    if (dot_on !== 1'b0 || in_frame !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: dot/in actual %b/%b expected 0/0", dot_on, in_frame);
    end
    set_mode(4, 0, 0, '0);
    run_line(300, 0);
    check_line(0, 300, "R1");
  endtask

  // R2 R3 R4 R5 R10: normal rows, offset frame
  task automatic test_normal();
    set_mode(20, 3, 0, '0);
    run_frame(600, 19, '{2, 3, 5, 18, 19}, '{"R5", "R4", "R3", "R10", "R2"});
  endtask

  // R6: glyph lines repeated
  task automatic test_line_rep();
    set_mode(20, 2, 2, '0);
    run_frame(600, 8, '{2, 4, 5, 8}, '{"R6", "R6", "R6", "R6"});
  endtask

  // R7: tall row 0
  task automatic test_tall();
    set_mode(16, 1, 0, 20'b10);
    run_frame(600, 33, '{1, 2, 3, 32, 33}, '{"R7", "R7", "R7", "R7", "R7"});
  endtask

  // R8: wide row 0
  task automatic test_wide();
    set_mode(10, 1, 0, 20'b01);
    run_frame(600, 2, '{1, 2}, '{"R8", "R8"});
  endtask

  // R7 R8: row 1 both wide and tall below a normal row
  task automatic test_both();
    set_mode(12, 0, 0, 20'b1100);
    run_frame(600, 18, '{15, 16, 18}, '{"R3", "R7", "R8"});
  endtask

  // R9: last glyph line of row 9, then empty
  task automatic test_frame_end();
    set_mode(4, 0, 0, '0);
    run_frame(300, 160, '{159, 160}, '{"R9", "R9"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    for (int a = 0; a < 240; a++) write_cell(a, 8'((a * 37 + 11) % 256));
    write_cell(1, 8'h00);
    write_cell(2, 8'h80);
    write_cell(5, 8'h7F);
    write_cell(23, 8'hC1);
    test_normal();
    test_line_rep();
    test_tall();
    test_wide();
    test_both();
    test_frame_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule